// File: doc/BRIEF.md
# Oversampled Serial Character Receiver

This block recovers 8-bit characters from an asynchronous, idle-high serial line. A clock enable pulses at sixteen times the bit rate, and all bit timing is counted in those pulses. The line first passes through a synchronizer. A falling edge starts a counter, and the line is checked again at the centre of the candidate start bit. A pulse that has gone high again by then is discarded without any trace. Otherwise the block samples the data bits and the stop bit at their centres.

A completed character is placed in a holding register. A one-cycle valid strobe and a three-bit status word accompany it. A host read of the holding register clears the ready flag. It also clears the overrun flag.

Top module: `srx_receiver`

## Requirements
- R1: After reset the data output is zero, the valid strobe is low and all three status bits are low.
- R2: A low pulse that is high again at the start-bit centre sample, 8 ticks after the detected falling edge, is dropped. No strobe follows it, the status and the holding register do not change, and the next real character is still received.
- R3: Data bits are sampled every 16 ticks after the start-bit centre. The first bit received is the least significant bit of the data output.
- R4: Status bit 0 (ready) is set when a character completes. It is cleared by a one-cycle read strobe that does not coincide with a completion.
- R5: Status bit 1 (framing) is set when the stop-bit sample is low, and the character is still delivered. Each completed character updates this bit, so a good character clears it.
- R6: Status bit 2 (overrun) is set when a character completes while ready is still set and no read occurs in that cycle. The new byte replaces the old one. A read clears overrun.
- R7: The valid strobe is high for exactly one clock cycle per completed character.
- R8: The receiver accepts a start edge that follows a stop bit directly, so back-to-back frames with no idle gap are both received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Clock enable at 16 times the bit rate |
| rxd_in | input | 1 | Asynchronous serial line, idle high |
| rd_strobe | input | 1 | One-cycle host read of the holding register |
| data_out | output | 8 | Holding register contents |
| data_valid | output | 1 | One-cycle strobe when a character is stored |
| rx_status | output | 3 | {overrun, framing, ready} |

## Verification
The valid strobe, the holding register and the status bits all change one clock after the tick that samples the stop-bit centre. That tick falls about half a bit before the end of the frame. The start-bit check completes 8 ticks after the falling edge, and that edge is seen three clocks after the line changes. The bench therefore sends a whole frame and then samples on the falling clock edge. By then every result of the frame has settled, and no later frame has begun. A monitor counts strobes and the length of each strobe. Read effects are checked one cycle after the read strobe.

// File: rtl/srx_pkg.sv
package srx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } srx_state_e;

  // Tick index (from zero) at which the start bit centre is sampled.
  function automatic int centre_tick(input int ovs);
    return ovs / 2 - 1;
  endfunction

  // Tick index (from zero) closing a full bit period.
  function automatic int bit_end_tick(input int ovs);
    return ovs - 1;
  endfunction

  // Overrun flag next-state rule.
  function automatic logic next_overrun(input logic done, input logic ready,
                                        input logic rd, input logic cur);
    if (done) return (ready && !rd) ? 1'b1 : (cur && !rd);
    if (rd)   return 1'b0;
    return cur;
  endfunction

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic line_q,
  output logic fall_evt
);
  logic [STAGES-1:0] chain;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain  <= '1;
      prev_q <= 1'b1;
    end else begin
      chain[0] <= din;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      prev_q <= chain[STAGES-1];
    end
  end

  assign line_q   = chain[STAGES-1];
  assign fall_evt = prev_q & ~line_q;
endmodule

// File: rtl/srx_timing.sv
module srx_timing
  import srx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              line,
  input  logic              fall_evt,
  output logic [DATA_W-1:0] char_q,
  output logic              done_evt,
  output logic              abort_evt,
  output logic              stop_ok,
  output logic              busy
);
  localparam int CNT_W = $clog2(OVS);
  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] CTR_MID  = CNT_W'(centre_tick(OVS));
  localparam logic [CNT_W-1:0] CTR_END  = CNT_W'(bit_end_tick(OVS));
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W - 1);

  srx_state_e       state;
  logic [CNT_W-1:0] cnt;
  logic [BIT_W-1:0] bit_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      bit_idx <= '0;
      char_q  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          cnt     <= '0;
          bit_idx <= '0;
          if (fall_evt) state <= ST_START;
        end
        ST_START: if (tick) begin
          if (cnt == CTR_MID) begin
            cnt   <= '0;
            state <= line ? ST_IDLE : ST_DATA;
          end else cnt <= cnt + 1'b1;
        end
        ST_DATA: if (tick) begin
          if (cnt == CTR_END) begin
            cnt    <= '0;
            char_q <= {line, char_q[DATA_W-1:1]};
            if (bit_idx == BIT_LAST) begin
              bit_idx <= '0;
              state   <= ST_STOP;
            end else bit_idx <= bit_idx + 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        ST_STOP: if (tick) begin
          if (cnt == CTR_END) begin
            cnt   <= '0;
            state <= ST_IDLE;
          end else cnt <= cnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign done_evt  = tick && (state == ST_STOP) && (cnt == CTR_END);
  assign abort_evt = tick && (state == ST_START) && (cnt == CTR_MID) && line;
  assign stop_ok   = line;
  assign busy      = (state != ST_IDLE);
endmodule

// File: rtl/srx_hold.sv
module srx_hold
  import srx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done_evt,
  input  logic              stop_ok,
  input  logic [DATA_W-1:0] char_in,
  input  logic              rd,
  output logic [DATA_W-1:0] data_q,
  output logic              valid_q,
  output logic              ready_q,
  output logic              frame_q,
  output logic              overrun_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q    <= '0;
      valid_q   <= 1'b0;
      ready_q   <= 1'b0;
      frame_q   <= 1'b0;
      overrun_q <= 1'b0;
    end else begin
      valid_q   <= done_evt;
      overrun_q <= next_overrun(done_evt, ready_q, rd, overrun_q);
      if (done_evt) begin
        data_q  <= char_in;
        ready_q <= 1'b1;
        frame_q <= ~stop_ok;
      end else if (rd) begin
        ready_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/srx_receiver.sv
module srx_receiver #(
  parameter int DATA_W      = 8,
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              rxd_in,
  input  logic              rd_strobe,
  output logic [DATA_W-1:0] data_out,
  output logic              data_valid,
  output logic [2:0]        rx_status
);
  logic              line_s;
  logic              fall_evt;
  logic              done_evt;
  logic              abort_evt;
  logic              stop_ok;
  logic              busy;
  logic [DATA_W-1:0] char_q;
  logic              ready_q, frame_q, overrun_q;

  srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rxd_in),
    .line_q(line_s), .fall_evt(fall_evt)
  );

  srx_timing #(.DATA_W(DATA_W), .OVS(OVS)) u_timing (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .line(line_s),
    .fall_evt(fall_evt), .char_q(char_q), .done_evt(done_evt),
    .abort_evt(abort_evt), .stop_ok(stop_ok), .busy(busy)
  );

  srx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .done_evt(done_evt), .stop_ok(stop_ok),
    .char_in(char_q), .rd(rd_strobe), .data_q(data_out),
    .valid_q(data_valid), .ready_q(ready_q), .frame_q(frame_q),
    .overrun_q(overrun_q)
  );

  assign rx_status = {overrun_q, frame_q, ready_q};
endmodule

// File: rtl/srx_checker.sv
module srx_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fall_evt,
  input logic              busy,
  input logic              done_evt,
  input logic              abort_evt,
  input logic              stop_ok,
  input logic              rd,
  input logic              valid,
  input logic [DATA_W-1:0] data,
  input logic [2:0]        status
);
  a_r2_start_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(fall_evt));
  a_r2_abort_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> !valid);
  a_r3_data_known: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> !$isunknown(data));
  a_r4_ready_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> status[0]);
  a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !done_evt) |=> !status[0]);
  a_r5_frame_set: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt && !stop_ok) |=> status[1]);
  a_r6_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt && status[0] && !rd) |=> status[2]);
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);
endmodule

bind srx_receiver srx_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fall_evt(fall_evt), .busy(busy),
  .done_evt(done_evt), .abort_evt(abort_evt), .stop_ok(stop_ok),
  .rd(rd_strobe), .valid(data_valid), .data(data_out), .status(rx_status)
);

// File: tb/sim_srx_receiver.sv
`timescale 1ns/1ps
module sim_srx_receiver;
  localparam int TDIV   = 4;
  localparam int BITCLK = 16 * TDIV;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic       rxd_in = 1'b1;
  logic       rd_strobe = 1'b0;
  logic [7:0] data_out;
  logic       data_valid;
  logic [2:0] rx_status;

  int nchecks = 0;
  int nfail   = 0;
  int vcount  = 0;
  int run     = 0;
  int maxrun  = 0;
  bit ended   = 0;

  always #2.5 clk = ~clk;

  srx_receiver u0 (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd_in(rxd_in),
    .rd_strobe(rd_strobe), .data_out(data_out), .data_valid(data_valid),
    .rx_status(rx_status)
  );

  initial begin
    int c;
    c = 0;
    forever begin
      @(posedge clk);
      tick16 <= (c == TDIV - 1);
      c = (c == TDIV - 1) ? 0 : c + 1;
    end
  end

  always @(negedge clk) begin
    if (data_valid) begin
      vcount <= vcount + 1;
      run    <= run + 1;
      if (run + 1 > maxrun) maxrun <= run + 1;
    end else run <= 0;
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchecks++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle_bits(input int n);
    rxd_in = 1'b1;
    repeat (n * BITCLK) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] b, input logic stop);
    rxd_in = 1'b0;
    repeat (BITCLK) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd_in = b[i];
      repeat (BITCLK) @(negedge clk);
    end
    rxd_in = stop;
    repeat (BITCLK) @(negedge clk);
  endtask

  task automatic host_read();
    @(negedge clk);
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "data after reset", data_out, 8'h00);
    chk("R1", "valid after reset", data_valid, 1'b0);
    chk("R1", "status after reset", rx_status, 3'b000);
  endtask

  task automatic t_good(input logic [7:0] b);
    int v0;
    v0 = vcount;
    send_frame(b, 1'b1);
    chk("R7", "one strobe per char", vcount - v0, 1);
    chk("R3", "byte LSB first", data_out, b);
    chk("R4", "ready after char", rx_status, 3'b001);
    host_read();
    chk("R4", "ready cleared by read", rx_status, 3'b000);
    idle_bits(1);
  endtask

  task automatic t_glitch();
    int v0;
    send_frame(8'h6E, 1'b1);
    idle_bits(1);
    v0 = vcount;
    rxd_in = 1'b0;
    repeat (5 * TDIV) @(negedge clk);
    idle_bits(2);
    chk("R2", "no strobe for glitch", vcount - v0, 0);
    chk("R2", "status unchanged by glitch", rx_status, 3'b001);
    chk("R2", "holding reg unchanged", data_out, 8'h6E);
    host_read();
    send_frame(8'hC3, 1'b1);
    chk("R2", "char after glitch", data_out, 8'hC3);
    host_read();
    idle_bits(1);
  endtask

  task automatic t_frame();
    send_frame(8'h5A, 1'b0);
    chk("R5", "byte kept on framing err", data_out, 8'h5A);
    chk("R5", "framing flag set", rx_status, 3'b011);
    idle_bits(1);
    host_read();
    send_frame(8'h96, 1'b1);
    chk("R5", "framing cleared by good char", rx_status, 3'b001);
    host_read();
    idle_bits(1);
  endtask

  task automatic t_overrun();
    int v0;
    v0 = vcount;
    send_frame(8'h11, 1'b1);
    send_frame(8'h22, 1'b1);
    chk("R8", "back-to-back both received", vcount - v0, 2);
    chk("R6", "new byte overwrites", data_out, 8'h22);
    chk("R6", "overrun set", rx_status, 3'b101);
    host_read();
    chk("R6", "read clears overrun and ready", rx_status, 3'b000);
    idle_bits(1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    idle_bits(1);
    t_good(8'hA5);
    t_good(8'h00);
    t_good(8'hFF);
    t_good(8'h01);
    t_good(8'h3C);
    t_glitch();
    t_frame();
    t_overrun();
    chk("R7", "strobe width one cycle", maxrun, 1);
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      nchecks++;
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfail);
      $finish;
    end
  end
endmodule